// File: doc/BRIEF.md
# Dual-Edge Capture Demodulation Timer

This block times a digital waveform with a single 16-bit counter. Once enabled it waits, with the count held at a programmable start value, until the first edge of the selected polarity arrives on the input. From then on the count advances on a clock tick. The tick is the system clock divided by a power of two.

While the counter runs, each qualifying rising edge copies the present count into a rising-edge capture register. Each qualifying falling edge copies it into a separate falling-edge capture register. The counter does not stop, so software can derive both the high and the low time of the waveform from successive captures.

When the count equals the reload value on a tick, the count returns to the start value and a sticky reload flag is raised. The interrupt pulse always reports captures. A configuration bit decides whether it also reports reloads.

Top module: `edge_capture_timer`

## Requirements
- R1: During reset, count, both capture registers, irq and reload_flag all read 0x0000 / 0.
- R2: With enable high and no trigger edge seen yet, count holds start_val and never advances. The first enabled edge arms the counter. The count then advances on the following ticks, and the arming edge itself captures nothing.
- R3: edge_sel selects the edges used both to trigger and to capture: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both. An edge of a polarity that is not selected neither arms the counter nor changes a capture register.
- R4: While running, a qualifying rising edge stores the current count in cap_rise without disturbing the count.
- R5: While running, a qualifying falling edge stores the current count in cap_fall without disturbing the count.
- R6: On a tick where count equals reload_val, the count becomes start_val on the next cycle and reload_flag becomes 1.
- R7: While running, the count changes only on ticks, once every 2^prescale clock cycles. The first tick comes 2^prescale cycles after the counter is armed.
- R8: irq is a one-cycle pulse, high in the same cycle that a capture register takes its new value. A reload raises irq only when irq_on_reload is 1.
- R9: When a capture edge and a reload fall on the same tick, the capture stores the reload value (the count before reload), and both irq and reload_flag are raised.
- R10: reload_flag stays 1 until reload_clr is 1 in a cycle without a new reload event. A reload event in the same cycle as reload_clr leaves the flag at 1.
- R11: With enable low, the counter stops, count is loaded with start_val, edges capture nothing, and re-enabling waits for a new trigger edge.
- R12: sig_in passes through two synchronizing flops before edge detection. A change on sig_in at a clock edge is acted on at the third rising clock edge after it, using the count held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low stops and re-arms |
| edge_sel | input | 2 | Edge polarity select (see R3) |
| prescale | input | 3 | Tick divider exponent: divide by 2^prescale |
| irq_on_reload | input | 1 | 1: reloads also pulse irq |
| start_val | input | 16 | Count value after arming or reload |
| reload_val | input | 16 | Count value that triggers a reload |
| reload_clr | input | 1 | Write-one-to-clear for reload_flag |
| sig_in | input | 1 | Asynchronous waveform being measured |
| count | output | 16 | Current counter value |
| cap_rise | output | 16 | Count at the last captured rising edge |
| cap_fall | output | 16 | Count at the last captured falling edge |
| irq | output | 1 | One-cycle event pulse |
| reload_flag | output | 1 | Sticky reload indication |

## Verification
On every cycle, the assertions check several local behaviours. They check that the capture registers hold unless a qualifying edge arrives, and that the count steps by one on a tick, stays still between ticks and returns to the start value after a reload. They also check the flag's stickiness, the irq pulse following captures and the disarm on a low enable. Other behaviours need stimulus and a reference model in the bench. These are the exact capture latency through the synchronizer, the trigger-polarity gating, and a capture that lands on the reload tick. So are prescaler spacing across settings and re-arming after enable drops.

// File: rtl/ect_pkg.sv
// Shared types for the dual-edge capture timer.
// Assumes: edge_sel encodings as stated in the brief (R3).
package ect_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_FALL     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_mode_e;

    // Returns {rise_enable, fall_enable} for a polarity mode.
    function automatic logic [1:0] edge_enables(input edge_mode_e mode);
        logic [1:0] en;
        case (mode)
            EDGE_RISE: en = 2'b10;
            EDGE_FALL: en = 2'b01;
            default:   en = 2'b11;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/ect_input_sync.sv
// Synchronizes the asynchronous timer input through STAGES flops and
// emits single-cycle rise/fall pulses from the synchronized level.
// Assumes: STAGES >= 2; input idles low out of reset.
module ect_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= sig_in;
            end
        end else begin : g_next
            // Later stages shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~last_q;
    assign fall_o = ~chain[STAGES-1] & last_q;

    AST_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(sig_in, STAGES) && !$past(sig_in, STAGES + 1)); // R12
    AST_FALL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(sig_in, STAGES) && $past(sig_in, STAGES + 1)); // R12

endmodule

// File: rtl/ect_prescaler.sv
// Produces a one-cycle tick every 2^prescale clocks while run is high.
// The divide counter restarts from zero whenever run is low, so the first
// tick after arming comes 2^prescale cycles later.
// Assumes: prescale may change at any time; the mask follows immediately.
module ect_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);

    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Build the low-bit mask selected by the prescale exponent.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(prescale));
        end
    end

    // Free-running divide counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_q <= '0;
        else if (!run) div_q <= '0;
        else          div_q <= div_q + 1'b1;
    end

    assign tick = run && ((div_q & mask) == mask);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(tick) && $stable(prescale) && prescale != '0)
        |-> !tick); // R7

endmodule

// File: rtl/ect_counter_core.sv
// The 16-bit measurement counter with its arm state. While idle or disabled
// the count is held at start_val. A trigger edge arms the counter, which then
// steps on ticks and returns to start_val when it matches reload_val.
// Assumes: tick is only high while enable and running are both high.
module ect_counter_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic             tick,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic             reload_evt_o
);

    logic             running_q;
    logic [CNT_W-1:0] count_q;
    logic             at_reload;

    assign at_reload = (count_q == reload_val);

    // Arm state: cleared by a low enable, set by the first trigger edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          running_q <= 1'b0;
        else if (!enable)    running_q <= 1'b0;
        else if (!running_q) running_q <= trig;
    end

    // Counter: preload while idle, step on ticks, wrap to start on match.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count_q <= '0;
        else if (!enable || !running_q) count_q <= start_val;
        else if (tick) begin
            if (at_reload) count_q <= start_val;
            else           count_q <= count_q + 1'b1;
        end
    end

    assign running_o    = running_q;
    assign count_o      = count_q;
    assign reload_evt_o = enable && running_q && tick && at_reload;

    AST_IDLE_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running_q) |=> count_q == $past(start_val)); // R2
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !running_q && count_q == $past(start_val)); // R11
    AST_RELOAD_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        reload_evt_o |=> count_q == $past(start_val)); // R6
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running_q && tick && !reload_evt_o) |=> count_q == $past(count_q) + 1'b1); // R7
    AST_STALL_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running_q && !tick) |=> $stable(count_q)); // R7

endmodule

// File: rtl/edge_capture_timer.sv
// Top of the dual-edge capture timer. Gates synchronized edges by the
// selected polarity, arms the counter core, stores the count in the rising
// or falling capture register, and drives the irq pulse and reload flag.
// Assumes: configuration inputs are stable while a measurement is running;
// sig_in may be fully asynchronous.
module edge_capture_timer
    import ect_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       edge_sel,
    input  logic [PRE_W-1:0] prescale,
    input  logic             irq_on_reload,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload_clr,
    input  logic             sig_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic             irq,
    output logic             reload_flag
);

    logic             rise_edge, fall_edge;
    logic [1:0]       edge_en;
    logic             rise_hit, fall_hit, trig;
    logic             running, live, tick, reload_evt;
    logic             rise_go, fall_go;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] cap_rise_q, cap_fall_q;
    logic             irq_q, flag_q;

    ect_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise_o (rise_edge),
        .fall_o (fall_edge)
    );

    assign edge_en  = edge_enables(edge_mode_e'(edge_sel));
    assign rise_hit = rise_edge & edge_en[1];
    assign fall_hit = fall_edge & edge_en[0];
    assign trig     = rise_hit | fall_hit;
    assign live     = enable & running;
    assign rise_go  = live & rise_hit;
    assign fall_go  = live & fall_hit;

    ect_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (live),
        .prescale (prescale),
        .tick     (tick)
    );

    ect_counter_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .trig         (trig),
        .tick         (tick),
        .start_val    (start_val),
        .reload_val   (reload_val),
        .running_o    (running),
        .count_o      (count_w),
        .reload_evt_o (reload_evt)
    );

    // Rising-edge capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_rise_q <= '0;
        else if (rise_go) cap_rise_q <= count_w;
    end

    // Falling-edge capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_fall_q <= '0;
        else if (fall_go) cap_fall_q <= count_w;
    end

    // Interrupt pulse, aligned with the capture register update.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= rise_go | fall_go | (irq_on_reload & reload_evt);
    end

    // Sticky reload flag, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (reload_evt) flag_q <= 1'b1;
        else if (reload_clr) flag_q <= 1'b0;
    end

    assign count       = count_w;
    assign cap_rise    = cap_rise_q;
    assign cap_fall    = cap_fall_q;
    assign irq         = irq_q;
    assign reload_flag = flag_q;

    AST_RISE_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_go |=> $stable(cap_rise)); // R4
    AST_FALL_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_go |=> $stable(cap_fall)); // R5
    AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_go || fall_go) |=> irq); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_go && !fall_go && !reload_evt) |=> !irq); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        reload_evt |=> reload_flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_flag && !reload_clr) |=> reload_flag); // R10
    AST_COINCIDENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_go && reload_evt) |=> cap_rise == $past(reload_val) && reload_flag && irq); // R9

endmodule

// File: tb/test_edge_capture_timer.sv
`timescale 1ns/1ps
module test_edge_capture_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  edge_sel = 2'b10;
    logic [2:0]  prescale = 3'd0;
    logic        irq_on_reload = 1'b0;
    logic [15:0] start_val = 16'h0000;
    logic [15:0] reload_val = 16'hFFFF;
    logic        reload_clr = 1'b0;
    logic        sig_in = 1'b0;
    logic [15:0] count, cap_rise, cap_fall;
    logic        irq, reload_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edge_capture_timer i_edge_capture_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .edge_sel(edge_sel),
        .prescale(prescale), .irq_on_reload(irq_on_reload),
        .start_val(start_val), .reload_val(reload_val), .reload_clr(reload_clr),
        .sig_in(sig_in), .count(count), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .irq(irq), .reload_flag(reload_flag)
    );

    // ---------------- reference model built from the requirements ----------
    logic        m_s1, m_s2, m_prev, m_run, m_irq, m_flag;
    logic [15:0] m_cnt, m_cr, m_cf;
    int          m_pc;
    logic        e_r, e_f, m_live, m_tk, m_rl;

    function automatic bit exp_tick(int pc, int p);
        return (pc % (1 << p)) == ((1 << p) - 1);
    endfunction

    function automatic bit rise_allowed(logic [1:0] sel);
        return sel != 2'b01;
    endfunction

    function automatic bit fall_allowed(logic [1:0] sel);
        return sel != 2'b00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_run <= 0; m_irq <= 0;
            m_flag <= 0; m_cnt <= 0; m_cr <= 0; m_cf <= 0; m_pc <= 0;
        end else begin
            e_r    = m_s2 && !m_prev && rise_allowed(edge_sel);
            e_f    = !m_s2 && m_prev && fall_allowed(edge_sel);
            m_live = enable && m_run;
            m_tk   = m_live && exp_tick(m_pc, int'(prescale));
            m_rl   = m_tk && (m_cnt == reload_val);
            m_s1 <= sig_in; m_s2 <= m_s1; m_prev <= m_s2;
            m_pc <= m_live ? m_pc + 1 : 0;
            if (!enable)      m_run <= 0;
            else if (!m_run)  m_run <= e_r || e_f;
            if (!m_live)      m_cnt <= start_val;
            else if (m_tk)    m_cnt <= m_rl ? start_val : m_cnt + 16'd1;
            if (m_live && e_r) m_cr <= m_cnt;
            if (m_live && e_f) m_cf <= m_cnt;
            m_irq <= (m_live && (e_r || e_f)) || (irq_on_reload && m_rl);
            if (m_rl)            m_flag <= 1;
            else if (reload_clr) m_flag <= 0;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R7 count vs model", count, m_cnt);
            chk("R4 cap_rise vs model", cap_rise, m_cr);
            chk("R5 cap_fall vs model", cap_fall, m_cf);
            chk("R8 irq vs model", {15'd0, irq}, {15'd0, m_irq});
            chk("R10 reload_flag vs model", {15'd0, reload_flag}, {15'd0, m_flag});
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] c;
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));

        // R1: reset state
        step(3);
        chk("R1 count in reset", count, 16'h0000);
        chk("R1 cap_rise in reset", cap_rise, 16'h0000);
        chk("R1 cap_fall in reset", cap_fall, 16'h0000);
        chk("R1 irq/flag in reset", {14'd0, irq, reload_flag}, 16'h0000);
        rst_n = 1'b1;

        // R2/R3: falling-only trigger, a rising edge must not arm
        start_val = 16'h0010; reload_val = 16'h0100; edge_sel = 2'b01;
        prescale = 3'd0; enable = 1'b1;
        step(2);
        sig_in = 1'b1;
        step(6);
        chk("R3 rise ignored in fall-only mode: count", count, 16'h0010);
        chk("R3 rise ignored: cap_rise", cap_rise, 16'h0000);
        sig_in = 1'b0;
        step(6);
        chk("R2 count after falling trigger", count, 16'h0013);
        chk("R2 trigger edge captures nothing", cap_fall, 16'h0000);

        // R3: rising edge in fall-only mode leaves capture alone
        sig_in = 1'b1;
        step(5);
        chk("R3 cap_rise unchanged", cap_rise, 16'h0000);

        // R5/R12: falling capture latency of three edges
        edge_sel = 2'b10;
        c = count;
        sig_in = 1'b0;
        step(3);
        chk("R5 R12 cap_fall latency", cap_fall, c + 16'd2);
        chk("R8 irq with capture", {15'd0, irq}, 16'h0001);
        step(1);
        chk("R8 irq single cycle", {15'd0, irq}, 16'h0000);
        c = count;
        sig_in = 1'b1;
        step(3);
        chk("R4 R12 cap_rise latency", cap_rise, c + 16'd2);

        // R9: capture on the reload tick
        enable = 1'b0; start_val = 16'h0000; reload_val = 16'h0004;
        step(2);
        enable = 1'b1;
        sig_in = 1'b0;   // falling edge arms
        step(4);
        while (count != 16'h0002) step(1);
        sig_in = 1'b1;
        step(3);
        chk("R9 capture holds pre-reload count", cap_rise, 16'h0004);
        chk("R9 flag with coincident capture", {15'd0, reload_flag}, 16'h0001);
        chk("R9 irq with coincident capture", {15'd0, irq}, 16'h0001);

        // R10/R11: disable, flag sticky, edges ignored, clear works
        enable = 1'b0;
        step(4);
        chk("R11 count returns to start", count, 16'h0000);
        chk("R10 flag sticky", {15'd0, reload_flag}, 16'h0001);
        c = cap_fall;
        sig_in = 1'b0;
        step(4);
        chk("R11 disabled edge ignored", cap_fall, c);
        reload_clr = 1'b1;
        step(1);
        reload_clr = 1'b0;
        chk("R10 flag cleared", {15'd0, reload_flag}, 16'h0000);

        // R6: reload value reached, flag and irq on reload
        irq_on_reload = 1'b1; start_val = 16'h0003; reload_val = 16'h0005;
        enable = 1'b1;
        sig_in = 1'b1;
        step(3);
        step(3);
        chk("R6 count back at start after reload", count, 16'h0003);
        chk("R6 flag after reload", {15'd0, reload_flag}, 16'h0001);

        // Constrained random segments checked against the model
        for (int seg = 0; seg < 300; seg++) begin
            enable = 1'b0;
            step(2);
            edge_sel      = 2'($urandom_range(0, 3));
            prescale      = 3'($urandom_range(0, 3));
            irq_on_reload = 1'($urandom_range(0, 1));
            start_val     = 16'($urandom_range(0, 20));
            reload_val    = start_val + 16'($urandom_range(0, 30));
            enable = 1'b1;
            for (int k = 0; k < 40; k++) begin
                if ($urandom_range(0, 3) == 0)  sig_in = ~sig_in;
                reload_clr = ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 63) == 0) enable = ~enable;
                step(1);
            end
            reload_clr = 1'b0;
        end

        finish_run();
    end

endmodule